// File: doc/BRIEF.md
# PCIe Root-Port Bring-Up Sequencer

This block is a hardware sequencer that takes a PCIe root-port controller out of reset with no processor involved. A single start pulse begins the sequence. The block first puts the controller into the state a root port needs: root-complex mode on, the PCI-to-PCI bridge class code in the identity word, and all four legacy INTx interrupt enables cleared. It then makes sure the fundamental reset (PERST#) has been held for the minimum time. Any time that has already passed since that reset was first asserted counts towards the minimum. After that it releases the controller, PHY, bridge and endpoint resets together.

Once the resets are released, the block polls the link-up status. It allows a fixed number of polls, and a fixed number of microsecond ticks separates one poll from the next. If the link comes up, the block raises done and reports how many polls it used. If every poll fails, the block raises fail and latches the link-training state code. It also flags any code that lies outside the defined range. A free-running one-microsecond tick sets all timing, so every time limit is a count of ticks.

Top module: `rp_bringup_seq`

## Requirements
- R1: While rst_n is low, and after it rises, the reset-release word is 4'b0000 (all resets asserted), done_o, fail_o and rc_mode_o are 0, polls_o is 0, and intx_en_o holds its reset value INTX_RST.
- R2: The reset-release word is active-low reset, so 1 means released. Bit 0 is the MAC, bit 1 the PHY, bit 2 the bridge and bit 3 the endpoint PERST#. All four bits are released in the same cycle, at the end of the hold.
- R3: Before the release, rc_mode_o is 1, intx_en_o is 4'b0000, id_word_o[31:8] is 24'h060400 and id_word_o[7:0] follows rev_id_i.
- R4: With elapsed time E, where 0 < E < HOLD_US, the block waits HOLD_US-E ticks. With a tick on every cycle, and counting the edge that samples start as edge 1, the release appears after edge HOLD_US-E+3.
- R5: With E >= HOLD_US there is no hold wait, and the release appears after edge 3.
- R6: With E = 0, the block asserts all four resets on the cycle after start and then waits the full HOLD_US ticks, so the release appears after edge HOLD_US+3.
- R7: link_up_i is sampled once per poll. When it is 1, done_o rises and polls_o gives the number of polls made, counting the successful one.
- R8: Between two polls the block waits POLL_US ticks. While no tick arrives, no further poll happens.
- R9: If POLL_MAX polls all find the link down, fail_o rises, polls_o equals POLL_MAX and ltssm_o holds ltssm_i as sampled at the last poll.
- R10: ltssm_unknown_o is 1 after a failure exactly when the captured code is above 5'h1A. A code of 5'h1A is still known.
- R11: Each accepted start clears done_o, fail_o, polls_o and ltssm_o. Exactly one of done_o or fail_o is then raised when the sequence ends, and the two are never high together.
- R12: A start pulse that arrives while a sequence is running is ignored. The reset word, the poll count and the flags carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| us_tick_i | input | 1 | One-microsecond tick, one cycle wide |
| elapsed_us_i | input | EW | Microseconds already spent in fundamental reset (0 = no record), sampled at start |
| link_up_i | input | 1 | Link-up status from the controller |
| ltssm_i | input | 5 | Current link-training state code |
| rev_id_i | input | 8 | Revision byte kept in the low byte of the identity word |
| rc_mode_o | output | 1 | Root-complex mode enable |
| id_word_o | output | 32 | Identity word: class code in 31:8, revision in 7:0 |
| intx_en_o | output | 4 | Legacy INTx interrupt enables |
| rst_rel_o | output | 4 | Reset-release lines (1 = released) |
| done_o | output | 1 | Link came up |
| fail_o | output | 1 | Polls exhausted without link |
| polls_o | output | PCW | Number of polls used |
| ltssm_o | output | 5 | Training state captured on failure |
| ltssm_unknown_o | output | 1 | Captured code outside the defined range |

## Verification
The bench builds the block with HOLD_US=20, POLL_MAX=4, POLL_US=3 and EW=16. With these values the full hold, a partly credited hold, an elapsed time exactly equal to the hold, and elapsed times above it all finish within a few dozen cycles, so the bench can check each release edge exactly. The short poll budget means that exhausting every poll, and so capturing the training state on failure, happens within one short scenario. The bench also stops the tick inside a poll interval, which shows that polls stall and that a start arriving during that pause is ignored.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CFG  = 3'd1,
    S_HOLD = 3'd2,
    S_POLL = 3'd3,
    S_WAIT = 3'd4
  } seq_state_t;

  localparam logic [23:0] CLASS_P2P_BRIDGE = 24'h060400;
  localparam logic [4:0]  LTSSM_LAST_CODE  = 5'h1A;
  localparam int          RST_LINES        = 4;
  localparam int          INTX_LINES       = 4;

  localparam int REL_MAC   = 0;
  localparam int REL_PHY   = 1;
  localparam int REL_BRG   = 2;
  localparam int REL_PERST = 3;
endpackage

// File: rtl/rp_dn_timer.sv
module rp_dn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rp_cfg_regs.sv
module rp_cfg_regs
  import rp_seq_pkg::*;
#(
  parameter logic [INTX_LINES-1:0] INTX_RST = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [7:0]            rev_id_i,
  output logic                  rc_mode_o,
  output logic [31:0]           id_word_o,
  output logic [INTX_LINES-1:0] intx_en_o
);
  logic                  rc_q;
  logic [23:0]           class_q;
  logic [INTX_LINES-1:0] intx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q    <= 1'b0;
      class_q <= '0;
      intx_q  <= INTX_RST;
    end else if (wr_i) begin
      rc_q    <= 1'b1;
      class_q <= CLASS_P2P_BRIDGE;
      intx_q  <= '0;
    end
  end

  assign rc_mode_o = rc_q;
  assign id_word_o = {class_q, rev_id_i};
  assign intx_en_o = intx_q;

  // R3
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rc_mode_o && (intx_en_o == '0)));
endmodule

// File: rtl/rp_seq_fsm.sv
module rp_seq_fsm
  import rp_seq_pkg::*;
#(
  parameter int HOLD_US  = 100000,
  parameter int POLL_MAX = 100,
  parameter int POLL_US  = 1000,
  parameter int EW       = 32,
  parameter int TW       = 17,
  parameter int PCW      = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [EW-1:0]        elapsed_us_i,
  input  logic                 link_up_i,
  input  logic [4:0]           ltssm_i,
  input  logic                 tmr_zero_i,
  output logic                 tmr_load_o,
  output logic [TW-1:0]        tmr_val_o,
  output logic                 cfg_wr_o,
  output logic [RST_LINES-1:0] rst_rel_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [PCW-1:0]       polls_o,
  output logic [4:0]           ltssm_o,
  output logic                 ltssm_unknown_o
);
  localparam logic [EW:0]    HOLD_EXT  = (EW+1)'(HOLD_US);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX);
  localparam logic [TW-1:0]  POLL_GAP  = TW'(POLL_US);

  seq_state_t           state_q, state_d;
  logic [EW-1:0]        elapsed_q, elapsed_d;
  logic [RST_LINES-1:0] rel_q, rel_d;
  logic                 done_q, done_d;
  logic                 fail_q, fail_d;
  logic [PCW-1:0]       polls_q, polls_d;
  logic [4:0]           ltssm_q, ltssm_d;
  logic                 unk_q, unk_d;
  logic [EW:0]          remain;
  logic [PCW-1:0]       polls_inc;

  // Hold still owed, with credit for elapsed time
  always_comb begin
    if (elapsed_q == '0) remain = HOLD_EXT;
    else if ({1'b0, elapsed_q} >= HOLD_EXT) remain = '0;
    else remain = HOLD_EXT - {1'b0, elapsed_q};
  end

  assign polls_inc = polls_q + 1'b1;

  always_comb begin
    state_d    = state_q;
    elapsed_d  = elapsed_q;
    rel_d      = rel_q;
    done_d     = done_q;
    fail_d     = fail_q;
    polls_d    = polls_q;
    ltssm_d    = ltssm_q;
    unk_d      = unk_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cfg_wr_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d   = S_CFG;
          elapsed_d = elapsed_us_i;
          done_d    = 1'b0;
          fail_d    = 1'b0;
          polls_d   = '0;
          ltssm_d   = '0;
          unk_d     = 1'b0;
        end
      end
      S_CFG: begin
        cfg_wr_o   = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(remain);
        if (elapsed_q == '0) rel_d = '0;
        state_d = S_HOLD;
      end
      S_HOLD: begin
        if (tmr_zero_i) begin
          rel_d   = '1;
          state_d = S_POLL;
        end
      end
      S_POLL: begin
        polls_d = polls_inc;
        if (link_up_i) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (polls_inc == POLL_LAST) begin
          fail_d  = 1'b1;
          ltssm_d = ltssm_i;
          unk_d   = (ltssm_i > LTSSM_LAST_CODE);
          state_d = S_IDLE;
        end else begin
          tmr_load_o = 1'b1;
          tmr_val_o  = POLL_GAP;
          state_d    = S_WAIT;
        end
      end
      S_WAIT: begin
        if (tmr_zero_i) state_d = S_POLL;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      elapsed_q <= '0;
      rel_q     <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      polls_q   <= '0;
      ltssm_q   <= '0;
      unk_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      elapsed_q <= elapsed_d;
      rel_q     <= rel_d;
      done_q    <= done_d;
      fail_q    <= fail_d;
      polls_q   <= polls_d;
      ltssm_q   <= ltssm_d;
      unk_q     <= unk_d;
    end
  end

  assign rst_rel_o       = rel_q;
  assign done_o          = done_q;
  assign fail_o          = fail_q;
  assign polls_o         = polls_q;
  assign ltssm_o         = ltssm_q;
  assign ltssm_unknown_o = unk_q;

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && fail_q));

  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= POLL_LAST);

  // R9
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> (polls_q == POLL_LAST));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q inside {S_CFG, S_HOLD, S_WAIT})) |=> (state_q != S_IDLE));

  // R7
  done_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (polls_q != '0));
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
  import rp_seq_pkg::*;
#(
  parameter int                    HOLD_US  = 100000,
  parameter int                    POLL_MAX = 100,
  parameter int                    POLL_US  = 1000,
  parameter int                    EW       = 32,
  parameter logic [INTX_LINES-1:0] INTX_RST = '1,
  localparam int                   TMAX     = (HOLD_US > POLL_US) ? HOLD_US : POLL_US,
  localparam int                   TW       = $clog2(TMAX + 1),
  localparam int                   PCW      = $clog2(POLL_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  us_tick_i,
  input  logic [EW-1:0]         elapsed_us_i,
  input  logic                  link_up_i,
  input  logic [4:0]            ltssm_i,
  input  logic [7:0]            rev_id_i,
  output logic                  rc_mode_o,
  output logic [31:0]           id_word_o,
  output logic [INTX_LINES-1:0] intx_en_o,
  output logic [RST_LINES-1:0]  rst_rel_o,
  output logic                  done_o,
  output logic                  fail_o,
  output logic [PCW-1:0]        polls_o,
  output logic [4:0]            ltssm_o,
  output logic                  ltssm_unknown_o
);
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          cfg_wr;

  rp_dn_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (us_tick_i),
    .zero_o     (tmr_zero)
  );

  rp_cfg_regs #(.INTX_RST(INTX_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (cfg_wr),
    .rev_id_i  (rev_id_i),
    .rc_mode_o (rc_mode_o),
    .id_word_o (id_word_o),
    .intx_en_o (intx_en_o)
  );

  rp_seq_fsm #(
    .HOLD_US  (HOLD_US),
    .POLL_MAX (POLL_MAX),
    .POLL_US  (POLL_US),
    .EW       (EW),
    .TW       (TW),
    .PCW      (PCW)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .elapsed_us_i    (elapsed_us_i),
    .link_up_i       (link_up_i),
    .ltssm_i         (ltssm_i),
    .tmr_zero_i      (tmr_zero),
    .tmr_load_o      (tmr_load),
    .tmr_val_o       (tmr_val),
    .cfg_wr_o        (cfg_wr),
    .rst_rel_o       (rst_rel_o),
    .done_o          (done_o),
    .fail_o          (fail_o),
    .polls_o         (polls_o),
    .ltssm_o         (ltssm_o),
    .ltssm_unknown_o (ltssm_unknown_o)
  );

  // R3
  cfg_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel_o[REL_PERST]) |->
      (rc_mode_o && (intx_en_o == '0) && (id_word_o[31:8] == CLASS_P2P_BRIDGE)));

  // R2
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_rel_o[REL_MAC] == rst_rel_o[REL_PHY]) &&
    (rst_rel_o[REL_BRG] == rst_rel_o[REL_PERST]) &&
    (rst_rel_o[REL_MAC] == rst_rel_o[REL_PERST]));
endmodule

// File: tb/rp_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module rp_bringup_seq_tb_top;
  localparam int HOLD  = 20;
  localparam int PMAX  = 4;
  localparam int PGAP  = 3;
  localparam int EWB   = 16;
  localparam int PCWB  = $clog2(PMAX + 1);

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            tick_en;
  logic [EWB-1:0]  elapsed;
  logic            link_up;
  logic [4:0]      ltssm;
  logic [7:0]      rev_id;
  logic            rc_mode;
  logic [31:0]     id_word;
  logic [3:0]      intx_en;
  logic [3:0]      rst_rel;
  logic            done;
  logic            fail;
  logic [PCWB-1:0] polls;
  logic [4:0]      ltssm_cap;
  logic            ltssm_unk;

  int n_tests;
  int n_fail;

  rp_bringup_seq #(
    .HOLD_US(HOLD), .POLL_MAX(PMAX), .POLL_US(PGAP), .EW(EWB), .INTX_RST(4'hF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(tick_en),
    .elapsed_us_i(elapsed), .link_up_i(link_up), .ltssm_i(ltssm),
    .rev_id_i(rev_id), .rc_mode_o(rc_mode), .id_word_o(id_word),
    .intx_en_o(intx_en), .rst_rel_o(rst_rel), .done_o(done), .fail_o(fail),
    .polls_o(polls), .ltssm_o(ltssm_cap), .ltssm_unknown_o(ltssm_unk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulse start and count edges until all four lines release
  task automatic start_and_time(input int e, output int n, output bit saw_low);
    n = 0;
    saw_low = 1'b0;
    @(negedge clk);
    elapsed = EWB'(e);
    start = 1'b1;
    while (n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (rst_rel == 4'h0) saw_low = 1'b1;
      if (rst_rel == 4'hF && (n > 1)) break;
    end
  endtask

  task automatic wait_end();
    for (int i = 0; i < 300; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rst_rel == 4'h0, "R1 release word in reset", rst_rel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rst_rel == 4'h0, "R1 release word after reset", rst_rel, 0);
    chk(!done && !fail, "R1 flags", {done, fail}, 0);
    chk(!rc_mode, "R1 rc mode", rc_mode, 0);
    chk(intx_en == 4'hF, "R1 intx reset value", intx_en, 4'hF);
    chk(polls == '0, "R1 polls", polls, 0);
  endtask

  task automatic t_hold(input int e, input int exp_n, input string req);
    int n;
    bit lo;
    do_reset();
    link_up = 1'b1;
    tick_en = 1'b1;
    rev_id  = 8'h5A;
    start_and_time(e, n, lo);
    chk(n == exp_n, req, n, exp_n);
    chk(rst_rel == 4'hF, "R2 all four released", rst_rel, 4'hF);
    chk(rc_mode && intx_en == 4'h0, "R3 mode and intx", {rc_mode, intx_en}, 5'h10);
    chk(id_word == 32'h0604005A, "R3 identity word", id_word, 32'h0604005A);
    wait_end();
    chk(done && !fail && polls == 1, "R7 done after one poll", {done, fail, 1'b0, polls}, 1);
  endtask

  task automatic t_zero_elapsed();
    int n;
    bit lo;
    do_reset();
    link_up = 1'b1;
    tick_en = 1'b1;
    start_and_time(30, n, lo);
    wait_end();
    chk(rst_rel == 4'hF, "R6 precondition released", rst_rel, 4'hF);
    start_and_time(0, n, lo);
    chk(lo, "R6 resets reasserted", lo, 1);
    chk(n == HOLD + 3, "R6 full hold", n, HOLD + 3);
    wait_end();
    chk(done && !fail, "R11 done only", {done, fail}, 2);
  endtask

  task automatic t_poll_pause();
    int n;
    bit lo;
    do_reset();
    link_up = 1'b0;
    tick_en = 1'b0;
    start_and_time(30, n, lo);
    chk(n == 3, "R5 no hold wait without tick", n, 3);
    @(negedge clk);
    chk(polls == 1, "R7 first poll", polls, 1);
    repeat (20) @(negedge clk);
    chk(polls == 1 && !done && !fail, "R8 no poll without tick", polls, 1);
    elapsed = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst_rel == 4'hF, "R12 start ignored, lines kept", rst_rel, 4'hF);
    chk(polls == 1, "R12 start ignored, polls kept", polls, 1);
    link_up = 1'b1;
    tick_en = 1'b1;
    wait_end();
    chk(done && !fail, "R7 done on second poll", {done, fail}, 2);
    chk(polls == 2, "R7 poll count", polls, 2);
  endtask

  task automatic t_fail(input logic [4:0] code, input bit exp_unk);
    int n;
    bit lo;
    int c;
    do_reset();
    link_up = 1'b0;
    tick_en = 1'b1;
    ltssm   = code;
    start_and_time(40, n, lo);
    c = 0;
    while (!done && !fail && c < 300) begin
      @(negedge clk);
      c++;
    end
    // 4 polls, gaps of PGAP ticks plus load and exit cycles
    chk(c == (PMAX - 1) * (PGAP + 2) + 1, "R8 poll spacing", c, (PMAX - 1) * (PGAP + 2) + 1);
    chk(fail && !done, "R9 fail raised", {done, fail}, 1);
    chk(polls == PMAX, "R9 polls exhausted", polls, PMAX);
    chk(ltssm_cap == code, "R9 state captured", ltssm_cap, code);
    chk(ltssm_unk == exp_unk, "R10 unknown flag", ltssm_unk, exp_unk);
    link_up = 1'b1;
    start_and_time(40, n, lo);
    chk(!fail && !done, "R11 flags cleared on start", {done, fail}, 0);
    wait_end();
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    tick_en = 1'b0;
    elapsed = '0;
    link_up = 1'b0;
    ltssm   = '0;
    rev_id  = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    t_hold(5, HOLD - 5 + 3, "R4 partial hold credit");
    t_hold(19, HOLD - 19 + 3, "R4 one tick owed");
    t_hold(HOLD, 3, "R5 elapsed equals hold");
    t_hold(25, 3, "R5 elapsed above hold");
    t_zero_elapsed();
    t_poll_pause();
    t_fail(5'h0B, 1'b0);
    t_fail(5'h1A, 1'b0);
    t_fail(5'h1F, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule